// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises characters onto an asynchronous line. Each character is framed by a low start bit and a high stop bit. The data bits go out least significant first. In the two nine-bit modes an extra bit follows the data. Every bit lasts exactly one period of an external baud tick.

The block has two buffering schemes, and an enable input picks one.

- **Single-buffer scheme.** A data write is accepted only while the transmitter is idle. A write made during a frame is dropped. The interrupt flag rises when the stop bit begins. The ninth bit is read from its input at the moment its slot starts.
- **Double-buffer scheme.** Writes land in a holding register. That register captures the ninth bit together with the byte. The holding register is handed to the shifter as soon as the shifter is free, or on the very tick at which the current stop bit ends. Back-to-back characters therefore need only one stop bit between them. In this scheme the interrupt flag marks "holding register empty".

Mode 0, the synchronous mode, never uses the holding register. The interrupt flag is cleared by a clear strobe or by an accepted write.

Top module: `uart_dbtx`

## Requirements
- R1: After reset the line `txd` is high, `tx_irq` is low and nothing is transmitted.
- R2: A frame is one 0 start bit, 8 data bits LSB first, a ninth bit only when `mode` is 2 or 3, then one 1 stop bit. Each bit lasts one baud-tick period, and `txd` changes only on cycles where `baud_tick` is high.
- R3: In the single-buffer scheme, a write to an idle transmitter is accepted. The start bit is driven at the first baud tick after the write cycle.
- R4: In the single-buffer scheme, a write made while a frame is in progress (up to the end of its stop bit) is ignored. The line returns to idle after the current frame and no further frame is sent.
- R5: In the single-buffer scheme, `tx_irq` is set on the tick that begins the stop bit.
- R6: In the single-buffer scheme, the ninth bit takes the value of `bit9_in` at the tick that starts the ninth-bit slot, so it may be changed after the data write.
- R7: In the double-buffer scheme, `bit9_in` is captured together with the data at the write. Later changes of `bit9_in` do not affect that character.
- R8: In the double-buffer scheme, a character written between the start bit and the stop bit of the current frame has its start bit on the tick that ends the current stop bit. There is exactly one stop bit and no idle gap.
- R9: In the double-buffer scheme, `tx_irq` is set when the holding register empties. That is one clock after a write to an idle transmitter, or on the tick that ends the current stop bit when a character is waiting.
- R10: In the double-buffer scheme, a write while the holding register is full is ignored.
- R11: With `mode` = 0, `dbuf_en` has no effect and the single-buffer behaviour applies.
- R12: `tx_irq` is cleared by `irq_clr` or by an accepted write. A set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data-register write strobe |
| wr_data | input | 8 | Character to transmit |
| bit9_in | input | 1 | Ninth-bit register value |
| dbuf_en | input | 1 | Double-buffer enable (1 = holding register in use) |
| mode | input | 2 | 0 synchronous, 1 eight-bit, 2 and 3 nine-bit |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| irq_clr | input | 1 | Clears the transmit interrupt flag |
| txd | output | 1 | Serial output line, idle high |
| tx_irq | output | 1 | Transmit interrupt flag |

## Verification
The bench records `txd` and `tx_irq` half a clock after every baud-tick edge, and indexes each record by tick number. Every write is placed one clock after a tick. A start bit is therefore due in the record of the very next tick, data bit k in the record k+1 later, and the stop bit one record after the last data or ninth bit. The stop-bit interrupt appears in the same record as the stop bit. The back-to-back start bit and the holding-empty interrupt are due in the record that follows the stop bit. The one check not tied to a tick is the double-buffer interrupt after a write to an idle transmitter. It is sampled one clock after the write, and the clock just before that is checked to show the flag still low.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

   typedef enum logic [1:0] {
      TXM_SYNC  = 2'd0,
      TXM_8BIT  = 2'd1,
      TXM_9FIX  = 2'd2,
      TXM_9VAR  = 2'd3
   } txmode_e;

   // Nine-bit frames in modes 2 and 3
   function automatic logic mode_has_ninth(input logic [1:0] m);
      return m[1];
   endfunction

   // Holding register is permitted only in the asynchronous modes
   function automatic logic mode_allows_hold(input logic [1:0] m);
      return m != TXM_SYNC;
   endfunction

endpackage

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_b9,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data,
   output logic              b9
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
         b9   <= 1'b0;
      end else if (wr && !full) begin
         full <= 1'b1;
         data <= wr_data;
         b9   <= wr_b9;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   // R10: a full holding register keeps its character until the shifter takes it
   a_r10_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(data) && $stable(b9)));

   // R9: a hand-over leaves the register empty
   a_r9_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (full && take) |=> !full);

endmodule

// File: rtl/uart_dbtx_shifter.sv
module uart_dbtx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              load_direct,
   input  logic [DATA_W-1:0] load_data,
   input  logic              nine_frame,
   input  logic              dbuf,
   input  logic              live_b9,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              hold_b9,
   output logic              take_hold,
   output logic              stop_begin,
   output logic              busy,
   output logic              txd
);

   localparam int POS_W = $clog2(DATA_W + 3);
   localparam logic [POS_W-1:0] LAST_8 = POS_W'(DATA_W + 1);
   localparam logic [POS_W-1:0] LAST_9 = POS_W'(DATA_W + 2);
   localparam logic [POS_W-1:0] SLOT_9 = POS_W'(DATA_W + 1);
   localparam logic [POS_W-1:0] DLAST  = POS_W'(DATA_W);

   logic              armed;
   logic [POS_W-1:0]  pos;
   logic [POS_W-1:0]  pos_nxt;
   logic [DATA_W-1:0] sh;
   logic              sh9;
   logic              frm9;
   logic              frm_db;
   logic              txd_q;
   logic [POS_W-1:0]  last;
   logic              at_last;
   logic              next_bit;

   function automatic logic pick_bit(input logic [DATA_W-1:0] v,
                                     input logic [POS_W-1:0] idx);
      logic r;
      r = 1'b1;
      for (int i = 0; i < DATA_W; i++) begin
         if (idx == POS_W'(i)) r = v[i];
      end
      return r;
   endfunction

   assign last    = frm9 ? LAST_9 : LAST_8;
   assign at_last = (pos == last);
   assign pos_nxt = pos + 1'b1;

   always_comb begin
      if (pos_nxt <= DLAST)
         next_bit = pick_bit(sh, pos);
      else if (frm9 && pos_nxt == SLOT_9)
         next_bit = frm_db ? sh9 : live_b9;
      else
         next_bit = 1'b1;
   end

   assign take_hold  = hold_full &&
                       (!busy || (baud_tick && !armed && at_last));
   assign stop_begin = baud_tick && busy && !armed && !at_last &&
                       (pos_nxt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         armed  <= 1'b0;
         pos    <= '0;
         sh     <= '0;
         sh9    <= 1'b0;
         frm9   <= 1'b0;
         frm_db <= 1'b0;
         txd_q  <= 1'b1;
      end else if (!busy && (load_direct || take_hold)) begin
         busy   <= 1'b1;
         armed  <= 1'b1;
         sh     <= load_direct ? load_data : hold_data;
         sh9    <= load_direct ? 1'b0 : hold_b9;
         frm9   <= nine_frame;
         frm_db <= dbuf;
      end else if (baud_tick && busy) begin
         if (armed) begin
            armed <= 1'b0;
            pos   <= '0;
            txd_q <= 1'b0;
         end else if (at_last) begin
            if (take_hold) begin
               sh     <= hold_data;
               sh9    <= hold_b9;
               frm9   <= nine_frame;
               frm_db <= dbuf;
               pos    <= '0;
               txd_q  <= 1'b0;
            end else begin
               busy <= 1'b0;
            end
         end else begin
            pos   <= pos_nxt;
            txd_q <= next_bit;
         end
      end
   end

   assign txd = txd_q;

   // R2: the line moves only on baud-tick cycles
   a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd_q));

   // R1: an idle shifter holds the line high
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd_q);

   // R8: a hand-over in mid-stream starts the next frame on that tick
   a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hold && busy) |=> !txd_q);

endmodule

// File: rtl/uart_dbtx_irq.sv
module uart_dbtx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end

   // R12: a set event wins and raises the flag
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   // R12: a clear without a set drops the flag
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx #(
   parameter int DATA_W   = 8,
   parameter bit USE_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit9_in,
   input  logic              dbuf_en,
   input  logic [1:0]        mode,
   input  logic              baud_tick,
   input  logic              irq_clr,
   output logic              txd,
   output logic              tx_irq
);
   import uart_dbtx_pkg::*;

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("uart_dbtx: DATA_W must lie in 5..16");
   end

   logic              dbuf_eff;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              hold_b9;
   logic              hold_wr;
   logic              take_hold;
   logic              stop_begin;
   logic              busy;
   logic              load_direct;
   logic              wr_accept;
   logic              irq_set;

   if (USE_HOLD) begin : g_hold
      assign dbuf_eff = dbuf_en && mode_allows_hold(mode);
      assign hold_wr  = wr_en && dbuf_eff;

      uart_dbtx_hold #(.DATA_W(DATA_W)) u_hold (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (hold_wr),
         .wr_data (wr_data),
         .wr_b9   (bit9_in),
         .take    (take_hold),
         .full    (hold_full),
         .data    (hold_data),
         .b9      (hold_b9)
      );
   end else begin : g_nohold
      logic unused_en;
      assign unused_en = dbuf_en;
      assign dbuf_eff  = 1'b0;
      assign hold_wr   = 1'b0;
      assign hold_full = 1'b0;
      assign hold_data = '0;
      assign hold_b9   = 1'b0;
   end

   assign load_direct = wr_en && !dbuf_eff && !busy;
   assign wr_accept   = load_direct || (hold_wr && !hold_full);
   assign irq_set     = dbuf_eff ? take_hold : stop_begin;

   uart_dbtx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_tick   (baud_tick),
      .load_direct (load_direct),
      .load_data   (wr_data),
      .nine_frame  (mode_has_ninth(mode)),
      .dbuf        (dbuf_eff),
      .live_b9     (bit9_in),
      .hold_full   (hold_full),
      .hold_data   (hold_data),
      .hold_b9     (hold_b9),
      .take_hold   (take_hold),
      .stop_begin  (stop_begin),
      .busy        (busy),
      .txd         (txd)
   );

   uart_dbtx_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_set),
      .clr   (irq_clr || wr_accept),
      .flag  (tx_irq)
   );

   // R4: a write during a single-buffered frame leaves the transmitter busy with that frame
   a_r4_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dbuf_en && busy && !baud_tick) |=> busy);

   // R11: in the synchronous mode the holding register never fills
   a_r11_sync_nohold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TXM_SYNC && !hold_full) |=> !hold_full);

endmodule

// File: tb/uart_dbtx_test.sv
module uart_dbtx_test;

   localparam int TDIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       bit9_in = 1'b0;
   logic       dbuf_en = 1'b0;
   logic [1:0] mode = 2'd1;
   logic       baud_tick = 1'b0;
   logic       irq_clr = 1'b0;
   logic       txd;
   logic       tx_irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic line_log [0:2047];
   logic irq_log  [0:2047];
   int   nt = 0;
   int   tcnt = 0;

   uart_dbtx uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .bit9_in(bit9_in), .dbuf_en(dbuf_en), .mode(mode),
      .baud_tick(baud_tick), .irq_clr(irq_clr),
      .txd(txd), .tx_irq(tx_irq)
   );

   always #5 clk = ~clk;

   // tick generator and per-tick line recorder, both at the falling edge
   always @(negedge clk) begin
      if (baud_tick && rst_n && nt < 2048) begin
         line_log[nt] = txd;
         irq_log[nt]  = tx_irq;
         nt = nt + 1;
      end
      if (!rst_n) begin
         tcnt = 0;
         baud_tick = 1'b0;
      end else begin
         baud_tick = (tcnt == TDIV - 1);
         tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n) @(posedge clk iff baud_tick);
      @(negedge clk);
      @(negedge clk);
   endtask

   // write aligned one clock after a tick; m is the record index of the next tick
   task automatic do_write(input logic [7:0] d, input logic b9, output int m);
      @(posedge clk iff baud_tick);
      @(negedge clk);
      wr_data = d;
      bit9_in = b9;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
      m = nt;
   endtask

   task automatic check_frame(input string req, input int s, input logic [7:0] d,
                              input bit nine, input logic b9);
      chk(req, "start bit", line_log[s], 1'b0);
      for (int i = 0; i < 8; i++) chk(req, $sformatf("data bit %0d", i), line_log[s+1+i], d[i]);
      if (nine) chk(req, "ninth bit", line_log[s+9], b9);
      chk(req, "stop bit", line_log[s+9+int'(nine)], 1'b1);
   endtask

   task automatic t_reset;
      chk("R1", "txd after reset", txd, 1'b1);
      chk("R1", "irq after reset", tx_irq, 1'b0);
      wait_ticks(3);
      chk("R1", "line still idle", txd, 1'b1);
   endtask

   task automatic t_single_basic;
      int m;
      dbuf_en = 1'b0; mode = 2'd1;
      do_write(8'hA5, 1'b0, m);
      wait_ticks(12);
      check_frame("R2", m, 8'hA5, 1'b0, 1'b0);
      chk("R3", "start at first tick", line_log[m], 1'b0);
      chk("R5", "irq low before stop", irq_log[m+8], 1'b0);
      chk("R5", "irq at stop start", irq_log[m+9], 1'b1);
      chk("R2", "idle after frame", line_log[m+10], 1'b1);
   endtask

   task automatic t_single_ignore;
      int m, m2;
      dbuf_en = 1'b0; mode = 2'd1;
      do_write(8'h0F, 1'b0, m);
      do_write(8'h00, 1'b0, m2);
      wait_ticks(16);
      check_frame("R4", m, 8'h0F, 1'b0, 1'b0);
      for (int i = 10; i < 16; i++) chk("R4", "no second frame", line_log[m+i], 1'b1);
   endtask

   task automatic t_single_ninth;
      int m;
      dbuf_en = 1'b0; mode = 2'd3;
      do_write(8'h3C, 1'b0, m);
      bit9_in = 1'b1;
      wait_ticks(13);
      check_frame("R6", m, 8'h3C, 1'b1, 1'b1);
      chk("R5", "irq low in ninth slot", irq_log[m+9], 1'b0);
      chk("R5", "irq at nine-bit stop", irq_log[m+10], 1'b1);
   endtask

   task automatic t_double_stream;
      int m, m2;
      dbuf_en = 1'b1; mode = 2'd2;
      @(posedge clk iff baud_tick);
      @(negedge clk);
      wr_data = 8'h5A; bit9_in = 1'b1; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; bit9_in = 1'b0; m = nt;
      chk("R12", "write clears irq", tx_irq, 1'b0);
      @(negedge clk);
      chk("R9", "irq one clock after idle write", tx_irq, 1'b1);
      do_write(8'hC3, 1'b0, m2);
      chk("R12", "accepted write clears irq", tx_irq, 1'b0);
      bit9_in = 1'b1;
      wait_ticks(24);
      check_frame("R7", m, 8'h5A, 1'b1, 1'b1);
      check_frame("R8", m+11, 8'hC3, 1'b1, 1'b0);
      chk("R9", "irq low during stop", irq_log[m+10], 1'b0);
      chk("R9", "irq at hand-over tick", irq_log[m+11], 1'b1);
      chk("R8", "idle after stream", line_log[m+22], 1'b1);
      bit9_in = 1'b0;
   endtask

   task automatic t_double_full;
      int m, m2, m3;
      dbuf_en = 1'b1; mode = 2'd1;
      do_write(8'h81, 1'b0, m);
      do_write(8'h7E, 1'b0, m2);
      do_write(8'hFF, 1'b0, m3);
      wait_ticks(24);
      check_frame("R10", m, 8'h81, 1'b0, 1'b0);
      check_frame("R10", m+10, 8'h7E, 1'b0, 1'b0);
      for (int i = 20; i < 24; i++) chk("R10", "third write dropped", line_log[m+i], 1'b1);
   endtask

   task automatic t_sync_mode;
      int m, m2;
      dbuf_en = 1'b1; mode = 2'd0;
      do_write(8'h96, 1'b0, m);
      do_write(8'h11, 1'b0, m2);
      wait_ticks(16);
      check_frame("R11", m, 8'h96, 1'b0, 1'b0);
      chk("R11", "irq at stop start", irq_log[m+9], 1'b1);
      chk("R11", "irq low before stop", irq_log[m+8], 1'b0);
      for (int i = 10; i < 16; i++) chk("R11", "second write ignored", line_log[m+i], 1'b1);
   endtask

   task automatic t_irq_clear;
      chk("R12", "irq set before clear", tx_irq, 1'b1);
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R12", "irq cleared", tx_irq, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_basic();
      t_single_ignore();
      t_single_ninth();
      t_double_stream();
      t_double_full();
      t_sync_mode();
      t_irq_clear();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule